// File: doc/BRIEF.md
# Serial Flash Ready Poller

This block is the host side of a wait-for-ready loop on a serial flash. After a program or erase command has been sent elsewhere, a single-cycle `start` pulse makes the poller select the flash and send the status-read command 0xD7. It then keeps the serial clock running and reads status bytes back one after another, all inside one chip-select window. The flash repeats a fresh copy of its status byte for as long as it stays selected.

Each received byte is checked for the ready flag in its top bit. Polling ends when a byte shows ready, or when a software-chosen number of status bytes have been read without one. Chip select is then released on a byte boundary. The poller gives a one-cycle `done` pulse and holds the final status byte, its mismatch flag and a timeout flag until the next poll begins.

The serial clock uses SPI mode 0. It idles low and is made from the system clock by an enable that fires every `HALF_PERIOD` system cycles, so one serial clock period lasts 2·`HALF_PERIOD` system cycles.

Top module: `flash_busy_poller`

## Requirements
- R1: After `start`, chip select goes low and the 8 bits of 0xD7 are driven on `spi_mosi`, most significant bit first. MOSI changes only while `spi_sck` is low. It never changes during a high phase.
- R2: `spi_sck` is low whenever `spi_cs_n` is high. While selected, each half period of the serial clock lasts `HALF_PERIOD` system clock cycles.
- R3: Status bits are sampled on rising `spi_sck` edges, most significant bit first. Sampling starts with the ninth clock of the window and continues through successive status bytes without deselecting.
- R4: A status byte whose bit 7 is 1 ends the poll. `status_byte` then shows that byte and `timeout` is 0.
- R5: Chip select rises only after a whole number of status bytes (a multiple of 8 clocks after the command) has been clocked.
- R6: If `max_bytes` status bytes have been read and none has bit 7 set, the poll ends with `timeout` = 1 and `status_byte` equal to the last byte. A `max_bytes` of 0 behaves as 1. A ready flag on exactly the last allowed byte gives `timeout` = 0.
- R7: `compare_fail` equals bit 6 of the final status byte.
- R8: `done` is high for exactly one cycle, in the cycle when `spi_cs_n` returns high. The result outputs hold their values until the next accepted `start`.
- R9: A `start` pulse while a poll is running is ignored. It causes no extra `done` and no second poll.
- R10: `busy` is high from the cycle after an accepted `start` until the cycle of `done`. After reset, `busy` and `done` are 0 and `spi_cs_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a poll (single-cycle pulse) |
| max_bytes | input | CNT_W | Maximum number of status bytes to read |
| spi_miso | input | 1 | Serial data from flash |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to flash |
| busy | output | 1 | Poll in progress |
| done | output | 1 | One-cycle completion pulse |
| status_byte | output | 8 | Last status byte received |
| compare_fail | output | 1 | Bit 6 of the final status byte |
| timeout | output | 1 | Poll ended without a ready flag |

## Verification
The bench builds the poller with `HALF_PERIOD` = 2 and `CNT_W` = 6. Each serial clock is therefore four system cycles long, and polls of up to five status bytes finish within a few hundred cycles. The short divider makes it cheap to run many full command-plus-status windows against a behavioural flash model. That model records the command bits it receives and the number of clocks in each window. A 6-bit limit lets the bench cover the zero limit, a limit of one, and a ready flag landing exactly on the last permitted byte.

// File: rtl/poll_pkg.sv
package poll_pkg;

    localparam logic [7:0] STATUS_READ_OP = 8'hD7;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } poll_state_e;

endpackage

// File: rtl/poll_sck_tick.sv
module poll_sck_tick #(
    parameter int HALF_PERIOD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(HALF_PERIOD) + 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_PERIOD - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run || cnt_q == LAST) cnt_d = '0;
        else                       cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/poll_limit_cmp.sv
module poll_limit_cmp #(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] seen,
    input  logic [CNT_W-1:0] limit,
    output logic             at_limit
);
    logic [CNT_W:0] next_seen;

    always_comb begin
        next_seen = {1'b0, seen} + 1'b1;
        at_limit  = next_seen >= {1'b0, limit};
    end
endmodule

// File: rtl/flash_busy_poller.sv
module flash_busy_poller
    import poll_pkg::*;
#(
    parameter int HALF_PERIOD = 4,
    parameter int CNT_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] max_bytes,
    input  logic             spi_miso,
    output logic             spi_sck,
    output logic             spi_cs_n,
    output logic             spi_mosi,
    output logic             busy,
    output logic             done,
    output logic [7:0]       status_byte,
    output logic             compare_fail,
    output logic             timeout
);
    typedef struct packed {
        poll_state_e      state;
        logic             sck;
        logic             cs_n;
        logic             mosi;
        logic [2:0]       bit_cnt;
        logic             in_status;
        logic [7:0]       rx;
        logic [CNT_W-1:0] byte_cnt;
        logic [7:0]       status;
        logic             timeout;
        logic             done;
    } regs_t;

    regs_t r_d, r_q;
    logic  tick;
    logic  last_byte;

    poll_sck_tick #(.HALF_PERIOD(HALF_PERIOD)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (r_q.state == ST_SHIFT),
        .tick  (tick)
    );

    poll_limit_cmp #(.CNT_W(CNT_W)) u_limit (
        .seen     (r_q.byte_cnt),
        .limit    (max_bytes),
        .at_limit (last_byte)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.state     = ST_SHIFT;
                    r_d.cs_n      = 1'b0;
                    r_d.sck       = 1'b0;
                    r_d.mosi      = STATUS_READ_OP[7];
                    r_d.bit_cnt   = 3'd0;
                    r_d.in_status = 1'b0;
                    r_d.rx        = 8'h00;
                    r_d.byte_cnt  = '0;
                    r_d.timeout   = 1'b0;
                end
            end
            default: begin
                if (tick) begin
                    if (!r_q.sck) begin
                        r_d.sck = 1'b1;
                        if (r_q.in_status) r_d.rx = {r_q.rx[6:0], spi_miso};
                    end else begin
                        r_d.sck     = 1'b0;
                        r_d.bit_cnt = r_q.bit_cnt + 3'd1;
                        if (r_q.bit_cnt == 3'd7) begin
                            if (!r_q.in_status) begin
                                r_d.in_status = 1'b1;
                                r_d.mosi      = 1'b0;
                            end else if (r_q.rx[7] || last_byte) begin
                                r_d.state   = ST_IDLE;
                                r_d.cs_n    = 1'b1;
                                r_d.status  = r_q.rx;
                                r_d.timeout = !r_q.rx[7];
                                r_d.done    = 1'b1;
                            end else begin
                                r_d.byte_cnt = r_q.byte_cnt + 1'b1;
                            end
                        end else if (!r_q.in_status) begin
                            r_d.mosi = STATUS_READ_OP[3'd6 - r_q.bit_cnt];
                        end
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q           <= '0;
            r_q.state     <= ST_IDLE;
            r_q.cs_n      <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign spi_sck      = r_q.sck;
    assign spi_cs_n     = r_q.cs_n;
    assign spi_mosi     = r_q.mosi;
    assign busy         = (r_q.state == ST_SHIFT);
    assign done         = r_q.done;
    assign status_byte  = r_q.status;
    assign compare_fail = r_q.status[6];
    assign timeout      = r_q.timeout;

    // R2: clock held low while deselected
    a_r2_sck_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    // R1: MOSI frozen across a high phase
    a_r1_mosi_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

    // R8: done lasts one cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: deselect coincides with done
    a_r8_cs_rise_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> done);

    // R6: timeout only appears at completion
    a_r6_timeout_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout) |-> done);

    // R5: release only on a byte boundary
    a_r5_byte_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> (r_q.bit_cnt == 3'd0));
endmodule

// File: tb/flash_busy_poller_tb_top.sv
module flash_busy_poller_tb_top;
    localparam int HP = 2;
    localparam int CW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [CW-1:0] max_bytes = '0;
    logic          spi_miso = 1'b0;
    logic          spi_sck, spi_cs_n, spi_mosi, busy, done, compare_fail, timeout;
    logic [7:0]    status_byte;

    always #10 clk = ~clk;

    flash_busy_poller #(.HALF_PERIOD(HP), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .max_bytes(max_bytes),
        .spi_miso(spi_miso), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .busy(busy), .done(done),
        .status_byte(status_byte), .compare_fail(compare_fail), .timeout(timeout)
    );

    int total = 0;
    int bad = 0;
    int done_count = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // flash model
    logic [7:0] scr [8];
    int         scr_n = 1;
    int         m_bits = 0;
    logic [7:0] m_op = 8'h00;
    int         m_final_bits = 0;
    int         hi_cycles = 0;
    int         hi_len_err = 0;

    always @(negedge spi_cs_n or posedge spi_sck) begin
        if (spi_sck) begin
            if (!spi_cs_n) begin
                if (m_bits < 8) m_op = {m_op[6:0], spi_mosi};
                m_bits = m_bits + 1;
            end
        end else begin
            m_bits = 0;
            m_op = 8'h00;
        end
    end

    always @(negedge spi_sck) begin
        if (!spi_cs_n && m_bits >= 8) begin
            int bno;
            int pos;
            bno = (m_bits - 8) / 8;
            pos = (m_bits - 8) % 8;
            if (bno > scr_n - 1) bno = scr_n - 1;
            spi_miso = scr[bno][7 - pos];
        end
    end

    always @(posedge spi_cs_n) m_final_bits = m_bits;

    // R2: measure high-phase length in system cycles
    always @(posedge clk) begin
        if (spi_sck) hi_cycles <= hi_cycles + 1;
        else begin
            if (hi_cycles != 0 && hi_cycles != HP) hi_len_err <= hi_len_err + 1;
            hi_cycles <= 0;
        end
    end

    // scoreboard
    typedef struct {
        logic [7:0] st;
        logic       tout;
        int         nbytes;
    } exp_t;
    exp_t exp_q[$];

    always @(negedge clk) begin
        if (done) begin
            exp_t e;
            done_count++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected done", 1, 0);
            end else begin
                e = exp_q.pop_front();
                check(m_op == 8'hD7, "R1 opcode", m_op, 8'hD7);
                check(status_byte == e.st, "R4/R6 status_byte", status_byte, e.st);
                check(timeout == e.tout, "R6 timeout", timeout, e.tout);
                check(compare_fail == e.st[6], "R7 compare_fail", compare_fail, e.st[6]);
                check(m_final_bits == 8 + 8 * e.nbytes, "R3/R5 clocks in window",
                      m_final_bits, 8 + 8 * e.nbytes);
                check(spi_cs_n == 1'b1, "R8 cs high with done", spi_cs_n, 1);
                check(!spi_sck, "R2 sck low", spi_sck, 0);
            end
        end
    end

    task automatic run_poll(input int mx, input int n, input logic [7:0] b0,
                            input logic [7:0] b1, input logic [7:0] b2,
                            input logic [7:0] b3, input logic [7:0] b4,
                            input logic [7:0] est, input logic etout,
                            input int enb, input bit extra_start);
        exp_t e;
        int   dc0;
        scr[0] = b0; scr[1] = b1; scr[2] = b2; scr[3] = b3; scr[4] = b4;
        scr_n = n;
        e.st = est; e.tout = etout; e.nbytes = enb;
        exp_q.push_back(e);
        dc0 = done_count;
        @(negedge clk);
        max_bytes = CW'(mx);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R10 busy after start", busy, 1);
        check(spi_cs_n == 1'b0, "R1 cs low after start", spi_cs_n, 0);
        if (extra_start) begin
            repeat (20) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
        repeat (40) @(negedge clk);
        check(done_count == dc0 + 1, "R9 one done per poll", done_count - dc0, 1);
        check(spi_cs_n == 1'b1 && !busy, "R9 no second poll", spi_cs_n, 1);
        check(status_byte == est, "R8 result held", status_byte, est);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(spi_cs_n == 1'b1, "R10 reset cs", spi_cs_n, 1);
        check(busy == 1'b0 && done == 1'b0, "R10 reset busy/done", {busy, done}, 0);
        check(!spi_sck, "R2 reset sck", spi_sck, 0);
        rst_n = 1'b1;
        // R4: ready on first byte
        run_poll(10, 1, 8'hB4, 0, 0, 0, 0, 8'hB4, 1'b0, 1, 1'b0);
        // R3/R4/R7: three busy then ready with mismatch
        run_poll(10, 4, 8'h34, 8'h34, 8'h35, 8'hF5, 0, 8'hF5, 1'b0, 4, 1'b0);
        // R6: timeout after 3 bytes
        run_poll(3, 1, 8'h74, 0, 0, 0, 0, 8'h74, 1'b1, 3, 1'b0);
        // R6: zero limit acts as one
        run_poll(0, 1, 8'h34, 0, 0, 0, 0, 8'h34, 1'b1, 1, 1'b0);
        // R6: ready on last allowed byte
        run_poll(2, 2, 8'h34, 8'hB4, 0, 0, 0, 8'hB4, 1'b0, 2, 1'b0);
        // R9: start pulse during poll
        run_poll(10, 5, 8'h00, 8'h00, 8'h00, 8'h40, 8'hC1, 8'hC1, 1'b0, 5, 1'b1);
        check(hi_len_err == 0, "R2 half-period length", hi_len_err, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule